// File: doc/BRIEF.md
# Bus-activity conversion stall controller

This block sequences one successive-approximation conversion: a single sampling instant followed by a fixed number of bit trials, then a completion strobe. Each of those steps can be postponed while a bus-activity input is high, so that switching noise on a nearby digital bus does not land on a sensitive analog moment. The comparator, the result register and the bus decoder live elsewhere. The block issues only the timing strobes that drive them.

Two active-low enables, normally taken from a timer register whose reset value is zero, control the postponement. One enable covers the sampling instant and the other covers the bit trials. At zero the matching hold is active, and at one the matching step proceeds whatever the bus is doing. Holds stretch the conversion. A single bit trial that stays held for longer than a programmable number of clock cycles ends the conversion with an abort strobe instead of a completion strobe.

Top module: `conv_stall_ctrl`

## Requirements
- R1: After reset all four strobes are low and the block is idle. A start seen while idle begins a conversion, and with no hold in force the sample strobe is high in the cycle that follows the first clock edge after start was sampled.
- R2: With sampleHoldN at 0, the sampling instant is not issued in any cycle whose decision edge sees busBusy high. The sample strobe follows one cycle after the first cycle in the sampling phase with busBusy low.
- R3: With trialHoldN at 0, no bit trial is issued on a decision edge that sees busBusy high. Trials resume one per cycle once busBusy is low.
- R4: An enable at 1 disables its hold independently of the other, so that step proceeds with busBusy high. With both at 1 the conversion takes NUM_TRIALS+2 cycles from the start edge to the done strobe.
- R5: Exactly NUM_TRIALS trial strobes are issued per completed conversion, and the done strobe is high in the cycle right after the last trial strobe.
- R6: Within one bit trial, up to TIMEOUT_CYCLES consecutive held cycles are tolerated. A further held cycle raises the abort strobe in the next cycle, suppresses done and returns the block to idle. The held-cycle count restarts with every bit trial.
- R7: A start pulse that arrives while a conversion is in progress is ignored: no second sample strobe is issued.
- R8: At most one of the four strobes is high in any cycle, and each strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (accepted only when idle) |
| busBusy | input | 1 | High while the neighbouring bus is switching |
| sampleHoldN | input | 1 | 0 enables holding the sampling instant during bus activity |
| trialHoldN | input | 1 | 0 enables holding each bit trial during bus activity |
| samplePulse | output | 1 | One-cycle strobe at the sampling instant |
| trialPulse | output | 1 | One-cycle strobe per bit trial |
| donePulse | output | 1 | One-cycle strobe after the last bit trial |
| abortPulse | output | 1 | One-cycle strobe when a bit-trial hold times out |

## Verification
The assertions assume that busBusy and both enables are synchronous to clk and settle before each rising edge. They also assume the enables are steady for the whole of a conversion, so that a strobe can be related to the previous cycle's hold condition. The bench changes inputs only at falling edges and sets the enables before each start. It sweeps every enable pair against one or two busy windows of swept offset and length. The second window is separated from the first by one free cycle, so a trial slips in between and the timeout count must restart.

// File: rtl/conv_stall_pkg.sv
package conv_stall_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_TRIAL,
    ST_DONE
  } convState_t;

  typedef struct packed {
    logic sample;
    logic trial;
    logic done;
    logic abort;
    logic clrTrial;
    logic stallInc;
    logic stallClr;
  } ctlStrobes_t;

endpackage

// File: rtl/conv_stall_fsm.sv
module conv_stall_fsm
  import conv_stall_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        busBusy,
  input  logic        sampleHoldN,
  input  logic        trialHoldN,
  input  logic        lastTrial,
  input  logic        timedOut,
  output ctlStrobes_t ctl
);

  convState_t state, stateNext;
  logic sampleHeld, trialHeld;

  assign sampleHeld = busBusy && !sampleHoldN;
  assign trialHeld  = busBusy && !trialHoldN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) stateNext = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (!sampleHeld) begin
          ctl.sample   = 1'b1;
          ctl.clrTrial = 1'b1;
          ctl.stallClr = 1'b1;
          stateNext    = ST_TRIAL;
        end
      end
      ST_TRIAL: begin
        if (trialHeld) begin
          if (timedOut) begin
            ctl.abort = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            ctl.stallInc = 1'b1;
          end
        end else begin
          ctl.trial    = 1'b1;
          ctl.stallClr = 1'b1;
          if (lastTrial) stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        ctl.done  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/conv_stall_dp.sv
module conv_stall_dp
  import conv_stall_pkg::*;
#(
  parameter int NUM_TRIALS     = 12,
  parameter int TIMEOUT_CYCLES = 50,
  localparam int TRIAL_W = $clog2(NUM_TRIALS + 1),
  localparam int STALL_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  output logic               lastTrial,
  output logic               timedOut,
  output logic [STALL_W-1:0] stallCnt,
  output logic               samplePulse,
  output logic               trialPulse,
  output logic               donePulse,
  output logic               abortPulse
);

  logic [TRIAL_W-1:0] trialCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialCnt <= '0;
    end else if (ctl.clrTrial) begin
      trialCnt <= '0;
    end else if (ctl.trial) begin
      trialCnt <= trialCnt + TRIAL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallCnt <= '0;
    end else if (ctl.stallClr) begin
      stallCnt <= '0;
    end else if (ctl.stallInc) begin
      stallCnt <= stallCnt + STALL_W'(1);
    end
  end

  assign lastTrial = (trialCnt == TRIAL_W'(NUM_TRIALS - 1));
  assign timedOut  = (stallCnt == STALL_W'(TIMEOUT_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      samplePulse <= 1'b0;
      trialPulse  <= 1'b0;
      donePulse   <= 1'b0;
      abortPulse  <= 1'b0;
    end else begin
      samplePulse <= ctl.sample;
      trialPulse  <= ctl.trial;
      donePulse   <= ctl.done;
      abortPulse  <= ctl.abort;
    end
  end

endmodule

// File: rtl/conv_stall_ctrl.sv
module conv_stall_ctrl
  import conv_stall_pkg::*;
#(
  parameter int NUM_TRIALS     = 12,
  parameter int TIMEOUT_CYCLES = 50,
  localparam int STALL_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic busBusy,
  input  logic sampleHoldN,
  input  logic trialHoldN,
  output logic samplePulse,
  output logic trialPulse,
  output logic donePulse,
  output logic abortPulse
);

  ctlStrobes_t        ctl;
  logic               lastTrial;
  logic               timedOut;
  logic [STALL_W-1:0] stallCnt;

  conv_stall_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .busBusy     (busBusy),
    .sampleHoldN (sampleHoldN),
    .trialHoldN  (trialHoldN),
    .lastTrial   (lastTrial),
    .timedOut    (timedOut),
    .ctl         (ctl)
  );

  conv_stall_dp #(
    .NUM_TRIALS     (NUM_TRIALS),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .lastTrial   (lastTrial),
    .timedOut    (timedOut),
    .stallCnt    (stallCnt),
    .samplePulse (samplePulse),
    .trialPulse  (trialPulse),
    .donePulse   (donePulse),
    .abortPulse  (abortPulse)
  );

endmodule

// File: rtl/conv_stall_chk.sv
module conv_stall_chk #(
  parameter int TIMEOUT_CYCLES = 50,
  localparam int STALL_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               busBusy,
  input logic               sampleHoldN,
  input logic               trialHoldN,
  input logic               samplePulse,
  input logic               trialPulse,
  input logic               donePulse,
  input logic               abortPulse,
  input logic [STALL_W-1:0] stallCnt
);

  // R8: strobes are mutually exclusive
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({samplePulse, trialPulse, donePulse, abortPulse}));

  // R8: done and abort each last one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  a_r8_abort_single: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);

  // R2: a sample strobe never follows a held decision edge
  a_r2_sample_hold: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> !$past(busBusy && !sampleHoldN));

  // R3: a trial strobe never follows a held decision edge
  a_r3_trial_hold: assert property (@(posedge clk) disable iff (!rstN)
    trialPulse |-> !$past(busBusy && !trialHoldN));

  // R5: done comes straight after a trial strobe
  a_r5_done_after_trial: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(trialPulse));

  // R6: abort only after a held trial edge, and the count stays bounded
  a_r6_abort_cause: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(busBusy && !trialHoldN));
  a_r6_stall_bound: assert property (@(posedge clk) disable iff (!rstN)
    stallCnt <= STALL_W'(TIMEOUT_CYCLES));

endmodule

bind conv_stall_ctrl conv_stall_chk #(
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busBusy     (busBusy),
  .sampleHoldN (sampleHoldN),
  .trialHoldN  (trialHoldN),
  .samplePulse (samplePulse),
  .trialPulse  (trialPulse),
  .donePulse   (donePulse),
  .abortPulse  (abortPulse),
  .stallCnt    (stallCnt)
);

// File: tb/conv_stall_ctrl_bench.sv
module conv_stall_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int TO = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busBusy = 1'b0;
  logic sampleHoldN = 1'b0;
  logic trialHoldN = 1'b0;
  logic samplePulse, trialPulse, donePulse, abortPulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int k0 = 0;
  bit finished = 1'b0;

  int sampleCnt, trialCnt, doneCnt, abortCnt, overlapCnt;
  int sampleT, lastTrialT, doneT, abortT;

  conv_stall_ctrl #(.NUM_TRIALS(NT), .TIMEOUT_CYCLES(TO)) u_conv_stall_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busBusy(busBusy),
    .sampleHoldN(sampleHoldN), .trialHoldN(trialHoldN),
    .samplePulse(samplePulse), .trialPulse(trialPulse),
    .donePulse(donePulse), .abortPulse(abortPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (samplePulse) begin sampleCnt++; sampleT = cyc - k0; end
    if (trialPulse)  begin trialCnt++;  lastTrialT = cyc - k0; end
    if (donePulse)   begin doneCnt++;   doneT = cyc - k0; end
    if (abortPulse)  begin abortCnt++;  abortT = cyc - k0; end
    if (int'(samplePulse) + int'(trialPulse) + int'(donePulse) + int'(abortPulse) > 1)
      overlapCnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit busyAt(int c, int a, int len, bit twice);
    return (c >= a && c < a + len) ||
           (twice && c >= a + len + 1 && c < a + 2 * len + 1);
  endfunction

  // Expected event times, in cycles after the start edge, from the requirements
  task automatic expect_run(input bit sN, input bit tN, input int a, input int len,
                            input bit twice, output int eSample, output int eTrials,
                            output int eLast, output int eDone, output int eAbort);
    int c = 0;
    int held = 0;
    eTrials = 0; eLast = -1; eDone = -1; eAbort = -1;
    while (busyAt(c, a, len, twice) && !sN) c++;
    eSample = c + 1;
    c++;
    while (c < 500) begin
      if (busyAt(c, a, len, twice) && !tN) begin
        if (held == TO) begin eAbort = c + 1; break; end
        held++;
        c++;
      end else begin
        eTrials++;
        eLast = c + 1;
        held = 0;
        c++;
        if (eTrials == NT) begin eDone = c + 1; break; end
      end
    end
  endtask

  task automatic run(input bit sN, input bit tN, input int a, input int len,
                     input bit twice, input bit midStart);
    int eSample, eTrials, eLast, eDone, eAbort;
    string sTag;
    expect_run(sN, tN, a, len, twice, eSample, eTrials, eLast, eDone, eAbort);
    @(negedge clk);
    sampleHoldN = sN;
    trialHoldN = tN;
    busBusy = 1'b0;
    sampleCnt = 0; trialCnt = 0; doneCnt = 0; abortCnt = 0; overlapCnt = 0;
    sampleT = -1; lastTrialT = -1; doneT = -1; abortT = -1;
    k0 = cyc + 1;
    start = 1'b1;
    for (int i = 0; i < 45; i++) begin
      @(negedge clk);
      busBusy = busyAt(cyc - k0, a, len, twice);
      start = midStart && (cyc - k0 == 1);
    end
    busBusy = 1'b0;
    start = 1'b0;
    sTag = (sN && len > 0 && a == 0) ? "R4 sample unheld" : "R2 sample time";
    check(sampleT == eSample, sTag, sampleT, eSample);
    check(sampleCnt == 1, midStart ? "R7 single sample" : "R1 single sample", sampleCnt, 1);
    check(overlapCnt == 0, "R8 strobe overlap", overlapCnt, 0);
    if (eAbort >= 0) begin
      check(abortT == eAbort, "R6 abort time", abortT, eAbort);
      check(abortCnt == 1, "R6 abort count", abortCnt, 1);
      check(doneCnt == 0, "R6 no done on abort", doneCnt, 0);
      check(trialCnt == eTrials, "R6 trials before abort", trialCnt, eTrials);
    end else begin
      check(abortCnt == 0, twice ? "R6 stall count restarts" : "R6 no abort", abortCnt, 0);
      check(trialCnt == NT, "R5 trial count", trialCnt, NT);
      check(lastTrialT == eLast, tN ? "R4 trial unheld" : "R3 last trial time",
            lastTrialT, eLast);
      check(doneT == eDone, "R5 done time", doneT, eDone);
      check(doneT == lastTrialT + 1, "R5 done after last trial", doneT, lastTrialT + 1);
      check(doneCnt == 1, "R8 single done", doneCnt, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    sampleCnt = 0; trialCnt = 0; doneCnt = 0; abortCnt = 0; overlapCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check({samplePulse, trialPulse, donePulse, abortPulse} == 4'b0,
          "R1 reset strobes", int'({samplePulse, trialPulse, donePulse, abortPulse}), 0);
    check(sampleCnt + trialCnt + doneCnt + abortCnt == 0, "R1 idle without start",
          sampleCnt + trialCnt + doneCnt + abortCnt, 0);

    // Both holds off with the bus busy throughout: fixed length
    run(1'b1, 1'b1, 0, 30, 1'b0, 1'b0);
    check(doneT == NT + 2, "R4 both off length", doneT, NT + 2);

    for (int en = 0; en < 4; en++)
      for (int tw = 0; tw < 2; tw++)
        for (int a = 0; a < 8; a++)
          for (int len = 0; len < 7; len++)
            run(en[0], en[1], a, len, tw[0], a[0]);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule